// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit carries out the three vector configuration instructions of a vector-capable core. In the first form the requested length comes from a scalar register and the type comes from an immediate. In the second form the length is a 5-bit unsigned immediate and the type is an immediate. In the third form both come from registers, which is the form used to restore saved context. From the requested length (AVL), the type operand and the current vector state, the unit computes the new vector length (vl), the new vector type word (vtype) and the value that goes back to the destination register.

Decode supplies the instruction form, flags saying whether the rd and rs1 fields name the zero register, the rs1 value, the immediate, the type operand (zero-extended to XLEN when it comes from an immediate) and the current vl and vtype. A type the unit cannot support does not raise an exception. The result carries the illegal flag, and vl and every other type field are cleared to zero. Software then tests the sign bit of vtype to learn whether the type is supported.

The control is a two-state machine. `ST_IDLE` waits for work. The transition *accept* (`req_valid` high) registers the result and moves to `ST_RESULT`, where `rsp_valid` is high for that cycle. From `ST_RESULT` the transition *chain* (another request) stays in `ST_RESULT`, and *drain* (no request) returns to `ST_IDLE`.

Top module: `vcfg_unit`

## Requirements
- R1: With the register-length form (req_form 00 or 10/11) and rs1 not the zero register, AVL is rs1_val, vl = AVL when AVL ≤ VLMAX, and vl = VLMAX otherwise. This includes the range VLMAX < AVL < 2·VLMAX, where no balancing is done. vl is written to rd when rd is not the zero register.
- R2: When rs1 is the zero register and rd is not, in a register-length form, AVL is taken as all ones. vl = VLMAX and that value is written to rd.
- R3: When both rs1 and rd are the zero register, in a register-length form, vl keeps cur_vl, vtype takes the new type, and rd_we stays low. The request is legal only if the new VLMAX equals the VLMAX of cur_vtype. Otherwise the result is illegal (R6).
- R4: With req_form 01, AVL is the 5-bit uimm, zero-extended. The rs1 zero flag has no effect, so rs1_is_x0 = rd_is_x0 = 1 with uimm 0 gives vl 0 and never keeps cur_vl.
- R5: For any legal result that is not keep-vl, vl is nonzero exactly when AVL is nonzero.
- R6: An illegal result sets new_vtype to only bit XLEN-1, sets new_vl to 0, and writes 0 to rd when rd_we is high. No exception is raised.
- R7: The type is illegal if any bit of XLEN-1..8 of type_opnd is set, if vsew (bits 5:3) is 1xx, if vlmul (bits 2:0) is 100, or if VLEN·LMUL/SEW < 1. Here SEW = 8<<vsew, and vlmul 000/001/010/011 give 1/2/4/8 while 101/110/111 give 1/8, 1/4 and 1/2.
- R8: A legal new_vtype equals type_opnd, so vlmul sits in bits 2:0, vsew in bits 5:3, tail-agnostic in bit 6 and mask-agnostic in bit 7.
- R9: rsp_valid is high exactly one cycle after req_valid, and results appear in that cycle. Back-to-back requests give back-to-back results. With no request, new_vl and new_vtype hold and rd_we is low.
- R10: In reset, rsp_valid and rd_we are 0, new_vl is 0, and new_vtype has only bit XLEN-1 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_form | input | 2 | 00 register AVL + immediate type, 01 immediate AVL + immediate type, 10/11 register AVL + register type |
| rd_is_x0 | input | 1 | Destination field names the zero register |
| rs1_is_x0 | input | 1 | Source field names the zero register |
| rs1_val | input | XLEN | Register AVL value |
| uimm | input | 5 | Immediate AVL |
| type_opnd | input | XLEN | Requested type, immediates zero-extended |
| cur_vl | input | XLEN | Current vector length |
| cur_vtype | input | XLEN | Current vector type |
| rsp_valid | output | 1 | Result present this cycle |
| new_vl | output | XLEN | New vector length |
| new_vtype | output | XLEN | New vector type |
| rd_data | output | XLEN | Destination write-back value |
| rd_we | output | 1 | Destination write enable |

## Verification
The length computation is driven with AVL values of zero, below VLMAX, exactly VLMAX, between VLMAX and twice VLMAX, at twice VLMAX and far above it. These separate the clamp point from an off-by-one error and from a balancing rule. Type words cover every way a type can be illegal: a high reserved bit, the sign bit, a reserved vsew, a reserved vlmul and a fractional LMUL too small for the element width. Each is paired with a nearby legal word, so a checker that is too loose or too strict shows up. The zero-register combinations are crossed with all forms, and keep-vl is tried with a matching and a mismatching VLMAX. Requests are issued both spaced out and back to back, with idle gaps to show that the outputs hold.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

    typedef enum logic [1:0] {
        FORM_REG_IMM  = 2'b00,
        FORM_UIMM_IMM = 2'b01,
        FORM_REG_REG  = 2'b10,
        FORM_REG_ALT  = 2'b11
    } cfg_form_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } cfg_state_e;

    localparam int LMUL_LSB   = 0;
    localparam int SEW_LSB    = 3;
    localparam int TA_BIT     = 6;
    localparam int MA_BIT     = 7;
    localparam int FIELD_BITS = 8;

endpackage

// File: rtl/vcfg_type_check.sv
module vcfg_type_check #(
    parameter int XLEN = 64,
    parameter int VLEN = 128,
    parameter int VL_W = $clog2(VLEN) + 1
) (
    input  logic [XLEN-1:0] vtype_in,
    output logic [XLEN-1:0] vtype_out,
    output logic [VL_W-1:0] vlmax
);
    import vcfg_pkg::*;

    localparam int VLEN_LOG = $clog2(VLEN);
    localparam logic [XLEN-1:0] ILLEGAL_WORD = {1'b1, {(XLEN-1){1'b0}}};

    logic [2:0] lmul_code;
    logic [2:0] sew_code;
    logic       reserved_clear;
    logic       supported;
    int         lmul_log;
    int         exp_val;

    assign lmul_code      = vtype_in[LMUL_LSB +: 3];
    assign sew_code       = vtype_in[SEW_LSB +: 3];
    assign reserved_clear = (vtype_in[XLEN-1:FIELD_BITS] == '0);

    always_comb begin
        case (lmul_code)
            3'b000:  lmul_log = 0;
            3'b001:  lmul_log = 1;
            3'b010:  lmul_log = 2;
            3'b011:  lmul_log = 3;
            3'b101:  lmul_log = -3;
            3'b110:  lmul_log = -2;
            3'b111:  lmul_log = -1;
            default: lmul_log = 0;
        endcase
        exp_val   = VLEN_LOG + lmul_log - 3 - int'(sew_code);
        supported = reserved_clear && !sew_code[2] &&
                    (lmul_code != 3'b100) && (exp_val >= 0);
        vlmax = '0;
        for (int k = 0; k < VL_W; k++) begin
            if (supported && exp_val == k) vlmax = VL_W'(1) << k;
        end
        vtype_out = supported ? vtype_in : ILLEGAL_WORD;
    end

    // R7: a supported type always yields a power-of-two VLMAX; an unsupported one yields zero
    always_comb begin
        if (!$isunknown(vtype_in)) begin
            assert_vlmax_shape_R7: assert (vtype_out[XLEN-1] ? (vlmax == '0)
                                                             : ($countones(vlmax) == 1))
                else $error("vlmax shape wrong for vtype %h", vtype_in);
        end
    end

endmodule

// File: rtl/vcfg_len_calc.sv
module vcfg_len_calc #(
    parameter int XLEN = 64,
    parameter int VL_W = 8
) (
    input  logic [XLEN-1:0] avl,
    input  logic [VL_W-1:0] vlmax,
    input  logic            keep_vl,
    input  logic            legal,
    input  logic [XLEN-1:0] cur_vl,
    output logic [XLEN-1:0] vl
);
    logic [XLEN-1:0] vlmax_x;

    assign vlmax_x = {{(XLEN-VL_W){1'b0}}, vlmax};

    always_comb begin
        if (!legal)
            vl = '0;
        else if (keep_vl)
            vl = cur_vl;
        else if (avl <= vlmax_x)
            vl = avl;
        else
            vl = vlmax_x;
    end

    always_comb begin
        if (!$isunknown({avl, legal, keep_vl, vlmax}) && legal && !keep_vl) begin
            // R1: the new length never exceeds VLMAX
            assert_vl_bound_R1: assert (vl <= vlmax_x)
                else $error("vl %0d above vlmax %0d", vl, vlmax_x);
            // R5: zero length exactly when the requested length is zero
            assert_vl_zero_R5: assert ((vl == '0) == (avl == '0))
                else $error("vl/avl zero mismatch vl=%0d avl=%0d", vl, avl);
        end
    end

endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit #(
    parameter int XLEN = 64,
    parameter int VLEN = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [1:0]      req_form,
    input  logic            rd_is_x0,
    input  logic            rs1_is_x0,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [4:0]      uimm,
    input  logic [XLEN-1:0] type_opnd,
    input  logic [XLEN-1:0] cur_vl,
    input  logic [XLEN-1:0] cur_vtype,
    output logic            rsp_valid,
    output logic [XLEN-1:0] new_vl,
    output logic [XLEN-1:0] new_vtype,
    output logic [XLEN-1:0] rd_data,
    output logic            rd_we
);
    import vcfg_pkg::*;

    localparam int VL_W = $clog2(VLEN) + 1;
    localparam logic [XLEN-1:0] ILLEGAL_WORD = {1'b1, {(XLEN-1){1'b0}}};

    cfg_form_e       form;
    cfg_state_e      state_q, state_d;
    logic [XLEN-1:0] chk_new_vtype, chk_old_vtype;
    logic [VL_W-1:0] new_vlmax, old_vlmax;
    logic            keep_vl;
    logic            keep_ok;
    logic            legal;
    logic [XLEN-1:0] avl;
    logic [XLEN-1:0] calc_vl;
    logic [XLEN-1:0] calc_vtype;

    assign form = cfg_form_e'(req_form);

    vcfg_type_check #(.XLEN(XLEN), .VLEN(VLEN), .VL_W(VL_W)) u_new_type (
        .vtype_in  (type_opnd),
        .vtype_out (chk_new_vtype),
        .vlmax     (new_vlmax)
    );

    vcfg_type_check #(.XLEN(XLEN), .VLEN(VLEN), .VL_W(VL_W)) u_old_type (
        .vtype_in  (cur_vtype),
        .vtype_out (chk_old_vtype),
        .vlmax     (old_vlmax)
    );

    // AVL source and zero-register special cases
    always_comb begin
        keep_vl = 1'b0;
        unique case (form)
            FORM_UIMM_IMM: avl = {{(XLEN-5){1'b0}}, uimm};
            FORM_REG_IMM, FORM_REG_REG, FORM_REG_ALT: begin
                if (!rs1_is_x0) begin
                    avl = rs1_val;
                end else begin
                    avl     = '1;
                    keep_vl = rd_is_x0;
                end
            end
            default: avl = rs1_val;
        endcase
        keep_ok    = !chk_old_vtype[XLEN-1] && (old_vlmax == new_vlmax);
        legal      = !chk_new_vtype[XLEN-1] && (!keep_vl || keep_ok);
        calc_vtype = legal ? chk_new_vtype : ILLEGAL_WORD;
    end

    vcfg_len_calc #(.XLEN(XLEN), .VL_W(VL_W)) u_len (
        .avl     (avl),
        .vlmax   (new_vlmax),
        .keep_vl (keep_vl),
        .legal   (legal),
        .cur_vl  (cur_vl),
        .vl      (calc_vl)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: accept, chain, drain
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = req_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = req_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign rsp_valid = (state_q == ST_RESULT);

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_vl    <= '0;
            new_vtype <= ILLEGAL_WORD;
            rd_data   <= '0;
            rd_we     <= 1'b0;
        end else if (state_d == ST_RESULT) begin
            new_vl    <= calc_vl;
            new_vtype <= calc_vtype;
            rd_data   <= calc_vl;
            rd_we     <= !rd_is_x0;
        end else begin
            rd_we     <= 1'b0;
        end
    end

    // R9: result exactly one cycle after each request
    assert_rsp_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid)
        else $error("missing response");
    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rd_we && $stable(new_vl) && $stable(new_vtype)))
        else $error("outputs moved without a request");
    // R6: an illegal result clears everything but the flag
    assert_illegal_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && new_vtype[XLEN-1]) |-> (new_vl == '0 && new_vtype[XLEN-2:0] == '0))
        else $error("illegal result not cleared");
    // R1: write-back value is the new length
    assert_rd_is_vl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we |-> (rd_data == new_vl))
        else $error("rd_data differs from vl");
    // R3: zero destination never writes
    assert_keep_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rd_is_x0) |=> !rd_we)
        else $error("write to zero register");

endmodule

// File: tb/sim_vcfg_unit.sv
module sim_vcfg_unit;

    localparam int XLEN = 64;
    localparam int VLEN = 128;
    localparam logic [63:0] ILL = 64'h8000_0000_0000_0000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [1:0]      req_form = 2'b00;
    logic            rd_is_x0 = 1'b0;
    logic            rs1_is_x0 = 1'b0;
    logic [63:0]     rs1_val = '0;
    logic [4:0]      uimm = '0;
    logic [63:0]     type_opnd = '0;
    logic [63:0]     cur_vl = '0;
    logic [63:0]     cur_vtype = '0;
    logic            rsp_valid;
    logic [63:0]     new_vl, new_vtype, rd_data;
    logic            rd_we;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [63:0] vl;
        logic [63:0] vt;
        logic        we;
        string       tag;
    } exp_t;
    exp_t sb[$];
    logic [63:0] last_vl, last_vt;

    always #2.5 clk = ~clk;

    vcfg_unit #(.XLEN(XLEN), .VLEN(VLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_form(req_form),
        .rd_is_x0(rd_is_x0), .rs1_is_x0(rs1_is_x0), .rs1_val(rs1_val), .uimm(uimm),
        .type_opnd(type_opnd), .cur_vl(cur_vl), .cur_vtype(cur_vtype),
        .rsp_valid(rsp_valid), .new_vl(new_vl), .new_vtype(new_vtype),
        .rd_data(rd_data), .rd_we(rd_we)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // VLMAX per R7 arithmetic; 0 means unsupported
    function automatic longint ref_vlmax(input logic [63:0] vt);
        longint num, den, sew;
        if (vt[63:8] != 0 || vt[5]) return 0;
        sew = 8 << vt[4:3];
        case (vt[2:0])
            3'b000: begin num = 1; den = 1; end
            3'b001: begin num = 2; den = 1; end
            3'b010: begin num = 4; den = 1; end
            3'b011: begin num = 8; den = 1; end
            3'b101: begin num = 1; den = 8; end
            3'b110: begin num = 1; den = 4; end
            3'b111: begin num = 1; den = 2; end
            default: return 0;
        endcase
        return (VLEN * num) / (den * sew);
    endfunction

    task automatic send(input logic [1:0] f, input bit rd0, input bit rs10,
                        input logic [63:0] r1, input logic [4:0] im,
                        input logic [63:0] vt, input logic [63:0] cvl,
                        input logic [63:0] cvt, input string tag);
        exp_t e;
        longint vm, vmo;
        logic [63:0] avl;
        bit keep, ok;
        vm   = ref_vlmax(vt);
        vmo  = ref_vlmax(cvt);
        keep = (f != 2'b01) && rs10 && rd0;
        ok   = (vm != 0) && (!keep || (vmo != 0 && vmo == vm));
        if (f == 2'b01)  avl = {59'd0, im};
        else if (rs10)   avl = '1;
        else             avl = r1;
        e.tag = tag;
        e.we  = !rd0;
        if (!ok) begin
            e.vl = 0; e.vt = ILL;
        end else begin
            e.vt = vt;
            if (keep)                  e.vl = cvl;
            else if (avl <= 64'(vm))   e.vl = avl;
            else                       e.vl = 64'(vm);
        end
        sb.push_back(e);
        req_form = f; rd_is_x0 = rd0; rs1_is_x0 = rs10; rs1_val = r1; uimm = im;
        type_opnd = vt; cur_vl = cvl; cur_vtype = cvt; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compare results against the scoreboard
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                check(0, "R9 unexpected response", 64'(rsp_valid), 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(new_vl == e.vl, {e.tag, " vl"}, new_vl, e.vl);
                check(new_vtype == e.vt, {e.tag, " vtype"}, new_vtype, e.vt);
                check(rd_we == e.we, {e.tag, " rd_we"}, 64'(rd_we), 64'(e.we));
                if (e.we) check(rd_data == e.vl, {e.tag, " rd_data"}, rd_data, e.vl);
                last_vl = e.vl;
                last_vt = e.vt;
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    // vtype words: e32m1 VLMAX 4, e8m8 128, e16mf2 4, e8m1 16, e8mf8 2
    localparam logic [63:0] E32M1  = 64'h10;
    localparam logic [63:0] E32TAM = 64'hD0;
    localparam logic [63:0] E8M8   = 64'h03;
    localparam logic [63:0] E16MF2 = 64'h0F;
    localparam logic [63:0] E8M1   = 64'h00;
    localparam logic [63:0] E8MF8  = 64'h05;

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(rsp_valid == 0, "R10 rsp_valid in reset", 64'(rsp_valid), 0);
        check(rd_we == 0, "R10 rd_we in reset", 64'(rd_we), 0);
        check(new_vl == 0, "R10 vl in reset", new_vl, 0);
        check(new_vtype == ILL, "R10 vtype in reset", new_vtype, ILL);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 clamp points, spaced
        send(2'b00, 0, 0, 64'd3,    0, E32M1,  0, E32M1, "R1 avl below vlmax");
        @(negedge clk);
        send(2'b00, 0, 0, 64'd4,    0, E32M1,  0, E32M1, "R1 avl at vlmax");
        // back to back (R9)
        send(2'b00, 0, 0, 64'd5,    0, E32M1,  0, E32M1, "R1 avl between");
        send(2'b00, 0, 0, 64'd7,    0, E32TAM, 0, E32M1, "R1 R8 between, ta ma");
        send(2'b00, 0, 0, 64'd8,    0, E32M1,  0, E32M1, "R1 avl twice vlmax");
        send(2'b10, 0, 0, '1,       0, E8M8,   0, E32M1, "R1 huge avl reg form");
        send(2'b00, 1, 0, 64'd2,    0, E8MF8,  0, E32M1, "R1 no write rd zero");
        // R5 zero avl
        send(2'b00, 0, 0, 64'd0,    0, E8M8,   0, E32M1, "R5 avl zero");
        // R2
        send(2'b00, 0, 1, 64'd9,    0, E8M8,   0, E32M1, "R2 vlmax request");
        send(2'b11, 0, 1, 64'd1,    0, E16MF2, 0, E32M1, "R2 vlmax request alt form");
        @(negedge clk);
        // R3 keep-vl
        send(2'b00, 1, 1, 64'd0,    0, E16MF2, 64'd3, E32M1, "R3 keep same vlmax");
        send(2'b10, 1, 1, 64'd0,    0, E8M1,   64'd3, E32M1, "R3 keep vlmax differs");
        send(2'b00, 1, 1, 64'd0,    0, E32M1,  64'd2, 64'h4, "R3 keep old type illegal");
        // R4 immediate form
        send(2'b01, 0, 0, 64'd99,   5'd31, E8M1, 0, E32M1, "R4 uimm above vlmax");
        send(2'b01, 0, 1, 64'd99,   5'd7,  E8M1, 0, E32M1, "R4 uimm ignores rs1 flag");
        send(2'b01, 1, 1, 64'd0,    5'd0,  E8M1, 64'd5, E8M1, "R4 R5 uimm zero not keep");
        // R6/R7 unsupported types
        send(2'b10, 0, 0, 64'd3,    0, 64'h0010_0010, 0, E32M1, "R7 reserved mid bit");
        send(2'b10, 0, 0, 64'd3,    0, ILL | E32M1,   0, E32M1, "R7 sign bit set");
        send(2'b10, 0, 0, 64'd3,    0, 64'h100 | E32M1, 0, E32M1, "R7 bit 8 set");
        send(2'b00, 0, 0, 64'd3,    0, 64'h20,  0, E32M1, "R7 vsew reserved");
        send(2'b00, 0, 0, 64'd3,    0, 64'h04,  0, E32M1, "R7 vlmul reserved");
        send(2'b00, 0, 0, 64'd3,    0, 64'h1D,  0, E32M1, "R7 R6 vlmax below one");
        send(2'b00, 0, 0, 64'd3,    0, 64'h1F,  0, E32M1, "R7 e64 mf2 legal");
        // R9 hold during idle
        repeat (3) @(negedge clk);
        check(rd_we == 0, "R9 rd_we idle", 64'(rd_we), 0);
        check(new_vl == last_vl, "R9 vl holds", new_vl, last_vl);
        check(new_vtype == last_vt, "R9 vtype holds", new_vtype, last_vt);
        check(sb.size() == 0, "R9 all responses seen", 64'(sb.size()), 0);
        finish_run();
    end

endmodule